// File: doc/BRIEF.md
# Eigenpair Ordering Index Streamer

This block receives a set of `NF` eigenvalues and the `NF x NF` matrix whose columns are their eigenvectors. It then sends them out in order of significance, largest eigenvalue first. The data is never moved into sorted order. When `start_i` is accepted, the block copies both arrays into local registers. A selection pass then builds a permutation list of column indices. A streaming sequencer walks that list and reads each element from its original storage location.

The output is one data word per beat on a valid/ready channel. The first `NF` beats carry the sorted eigenvalues. The eigenvector columns follow in the same order, and each column is sent from row 0 up to row `NF-1`. `out_last_o` marks the final beat. While a job is running, `busy_o` stays high and any further start request is ignored. A typical use is as the back end of a PCA engine, placed between the eigen-solver and a consumer that needs the principal components in rank order.

Top module: `eig_order_stream`

## Requirements
- R1: During reset and right after it, `busy_o`, `out_valid_o` and `out_last_o` are low.
- R2: A `start_i` seen high on an edge while idle captures `vals_i` and `vecs_i` on that edge, and `busy_o` is high from the next cycle. Later changes on those inputs do not affect the job.
- R3: Eigenvalues are `DW`-bit signed two's complement numbers. Value `i` sits at bits `[i*DW +: DW]` of `vals_i`. They are ranked from largest to smallest.
- R4: When eigenvalues are equal, the one with the lower original index is sent first.
- R5: The first `NF` accepted beats carry the eigenvalues in ranked order.
- R6: The next `NF*NF` beats carry one eigenvector column per ranked eigenvalue, in ranked order. Each column is sent from row 0 to row `NF-1`. The element at row `r`, column `c` sits at bits `[(r*NF+c)*DW +: DW]` of `vecs_i`, and column `c` belongs to eigenvalue `c`.
- R7: `out_last_o` is high only on the final beat of a job, and only while `out_valid_o` is high.
- R8: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o`, `out_data_o` and `out_last_o` hold their values. The stream advances by exactly one beat per cycle in which both are high.
- R9: A `start_i` that arrives while `busy_o` is high is ignored, together with its input data.
- R10: `busy_o` falls in the cycle after the final beat is accepted. A `start_i` in that cycle begins a new job.
- R11: `out_valid_o` first goes high `NF*NF` clock cycles after the edge that accepts `start_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a job |
| vals_i | input | NF*DW | Eigenvalues, packed |
| vecs_i | input | NF*NF*DW | Eigenvector matrix, packed by row |
| busy_o | output | 1 | A job is in progress |
| out_valid_o | output | 1 | Output beat is valid |
| out_data_o | output | DW | Output beat data |
| out_last_o | output | 1 | Final beat of the job |
| out_ready_i | input | 1 | Consumer accepts the beat |

## Verification
The bench targets the following faults, each with the symptom it would produce:

- **Ties:** equal eigenvalues, including a fully flat set. A comparison that lets a later equal value win would swap indices, and the columns would come out in the wrong sequence.
- **Signed ranking:** negative eigenvalues. An unsigned comparison would rank them at the top.
- **Back-pressure:** sparse ready patterns. A stream that advances without a handshake would skip or repeat a beat, or change its data during a stall.
- **Input handling:** the bench corrupts the inputs after capture and sends a start request in the middle of a stream. A design that reads its ports live, or restarts on that request, would send the wrong data.
- **Timing:** the bench checks when the first valid beat appears and when busy falls. An off-by-one in the scan or the beat counters would show up there.

// File: rtl/eig_order_pkg.sv
package eig_order_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SORT = 2'd1,
        ST_SEND = 2'd2
    } ctl_st_e;

    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/eig_rank_select.sv
module eig_rank_select #(
    parameter int NF = 4,
    parameter int DW = 16,
    parameter int IW = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_i,
    input  logic [NF*DW-1:0]   vals_i,
    output logic               done_o,
    output logic [NF*IW-1:0]   order_o
);

    localparam logic [IW-1:0] LAST = IW'(NF - 1);

    typedef struct packed {
        logic              active;
        logic [IW-1:0]     rank;
        logic [IW-1:0]     scan;
        logic [IW-1:0]     cand;
        logic              have;
        logic [NF-1:0]     used;
        logic [NF*IW-1:0]  order;
    } sel_t;

    sel_t s_d, s_q;
    logic signed [DW-1:0] cur_v, best_v;
    logic                 take;
    logic [IW-1:0]        pick;
    logic                 commit;

    always_comb begin
        s_d    = s_q;
        done_o = 1'b0;
        cur_v  = $signed(vals_i[int'(s_q.scan)*DW +: DW]);
        best_v = $signed(vals_i[int'(s_q.cand)*DW +: DW]);
        take   = 1'b0;
        pick   = s_q.cand;
        commit = 1'b0;
        if (go_i) begin
            s_d        = '0;
            s_d.active = 1'b1;
        end else if (s_q.active) begin
            // strict compare keeps the earliest index among equal values
            take = !s_q.used[s_q.scan] && (!s_q.have || (cur_v > best_v));
            if (take) begin
                s_d.cand = s_q.scan;
                s_d.have = 1'b1;
            end
            if (s_q.scan == LAST) begin
                commit = 1'b1;
                pick   = take ? s_q.scan : s_q.cand;
                s_d.order[int'(s_q.rank)*IW +: IW] = pick;
                s_d.used[pick] = 1'b1;
                s_d.have = 1'b0;
                s_d.scan = '0;
                if (s_q.rank == LAST) begin
                    s_d.active = 1'b0;
                    done_o     = 1'b1;
                end else begin
                    s_d.rank = s_q.rank + 1'b1;
                end
            end else begin
                s_d.scan = s_q.scan + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign order_o = s_q.order;

    // each commit marks exactly one more index as taken
    assert_one_pick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && !go_i && s_q.scan == LAST)
        |=> ($countones(s_q.used) == $past($countones(s_q.used)) + 1));

    // a finished pass has placed every index in the list
    assert_full_list_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (&s_q.used));

    // the chosen index was still free
    assert_pick_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !s_q.used[pick]);

endmodule

// File: rtl/eig_beat_stream.sv
module eig_beat_stream #(
    parameter int NF = 4,
    parameter int DW = 16,
    parameter int IW = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go_i,
    input  logic [NF*IW-1:0]     order_i,
    input  logic [NF*DW-1:0]     vals_i,
    input  logic [NF*NF*DW-1:0]  vecs_i,
    output logic                 out_valid_o,
    output logic [DW-1:0]        out_data_o,
    output logic                 out_last_o,
    input  logic                 out_ready_i,
    output logic                 fin_o
);

    localparam logic [IW-1:0] LAST = IW'(NF - 1);

    typedef struct packed {
        logic          active;
        logic          phase;   // 0: eigenvalues, 1: vector columns
        logic [IW-1:0] col;
        logic [IW-1:0] row;
    } beat_t;

    beat_t b_d, b_q;
    logic [IW-1:0] sel_idx;
    logic          fire;

    always_comb begin
        sel_idx     = b_q.phase ? order_i[int'(b_q.col)*IW +: IW]
                                : order_i[int'(b_q.row)*IW +: IW];
        out_valid_o = b_q.active;
        out_data_o  = b_q.phase
                    ? vecs_i[(int'(b_q.row)*NF + int'(sel_idx))*DW +: DW]
                    : vals_i[int'(sel_idx)*DW +: DW];
        out_last_o  = b_q.active && b_q.phase && (b_q.col == LAST) && (b_q.row == LAST);
        fire        = b_q.active && out_ready_i;
        fin_o       = 1'b0;
        b_d         = b_q;
        if (go_i) begin
            b_d        = '0;
            b_d.active = 1'b1;
        end else if (fire) begin
            if (b_q.row == LAST) begin
                b_d.row = '0;
                if (!b_q.phase) begin
                    b_d.phase = 1'b1;
                end else if (b_q.col == LAST) begin
                    b_d.active = 1'b0;
                    fin_o      = 1'b1;
                end else begin
                    b_d.col = b_q.col + 1'b1;
                end
            end else begin
                b_d.row = b_q.row + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i)
        |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));

    assert_last_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_last_o |-> out_valid_o);

endmodule

// File: rtl/eig_order_stream.sv
module eig_order_stream #(
    parameter int NF = 4,
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [NF*DW-1:0]     vals_i,
    input  logic [NF*NF*DW-1:0]  vecs_i,
    output logic                 busy_o,
    output logic                 out_valid_o,
    output logic [DW-1:0]        out_data_o,
    output logic                 out_last_o,
    input  logic                 out_ready_i
);
    import eig_order_pkg::*;

    localparam int IW = idx_bits(NF);

    typedef struct packed {
        ctl_st_e               st;
        logic [NF*DW-1:0]      vals;
        logic [NF*NF*DW-1:0]   vecs;
    } ctl_t;

    ctl_t c_d, c_q;
    logic              sort_go;
    logic              sort_done;
    logic              send_fin;
    logic [NF*IW-1:0]  order;

    always_comb begin
        c_d     = c_q;
        sort_go = 1'b0;
        unique case (c_q.st)
            ST_IDLE: if (start_i) begin
                c_d.st   = ST_SORT;
                c_d.vals = vals_i;
                c_d.vecs = vecs_i;
                sort_go  = 1'b1;
            end
            ST_SORT: if (sort_done) c_d.st = ST_SEND;
            ST_SEND: if (send_fin)  c_d.st = ST_IDLE;
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign busy_o = (c_q.st != ST_IDLE);

    eig_rank_select #(.NF(NF), .DW(DW), .IW(IW)) u_select (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (sort_go),
        .vals_i  (c_q.vals),
        .done_o  (sort_done),
        .order_o (order)
    );

    eig_beat_stream #(.NF(NF), .DW(DW), .IW(IW)) u_stream (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (sort_done),
        .order_i     (order),
        .vals_i      (c_q.vals),
        .vecs_i      (c_q.vecs),
        .out_valid_o (out_valid_o),
        .out_data_o  (out_data_o),
        .out_last_o  (out_last_o),
        .out_ready_i (out_ready_i),
        .fin_o       (send_fin)
    );

    assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(c_q.vals) && $stable(c_q.vecs)));

    assert_valid_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> busy_o);

    assert_busy_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_ready_i && out_last_o) |=> !busy_o);

endmodule

// File: tb/tb_eig_order_stream.sv
module tb_eig_order_stream;
    localparam int NF  = 4;
    localparam int DW  = 16;
    localparam int TOT = NF + NF * NF;
    localparam int NCASE = 5;

    localparam logic [NF*DW-1:0] CASE_VALS [NCASE] = '{
        {16'd9,     16'd1,     16'd20,    16'd5},   // order 1,3,0,2
        {16'h0000,  16'hFFF6,  16'd7,     16'hFFFD},// -3,7,-10,0 -> 1,3,0,2
        {16'd6,     16'd2,     16'd6,     16'd6},   // ties -> 0,1,3,2
        {16'd4,     16'd4,     16'd4,     16'd4},   // flat -> 0,1,2,3
        {16'd10,    16'd20,    16'd30,    16'd40}   // already ordered
    };
    localparam logic [15:0] CASE_READY [NCASE] = '{
        16'hFFFF, 16'hA5A5, 16'h3333, 16'hFFFF, 16'h0F0F
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start_i = 1'b0;
    logic [NF*DW-1:0]    vals_i = '0;
    logic [NF*NF*DW-1:0] vecs_i = '0;
    logic                busy_o, out_valid_o, out_last_o;
    logic [DW-1:0]       out_data_o;
    logic                out_ready_i = 1'b0;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    eig_order_stream #(.NF(NF), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vals_i(vals_i),
        .vecs_i(vecs_i), .busy_o(busy_o), .out_valid_o(out_valid_o),
        .out_data_o(out_data_o), .out_last_o(out_last_o),
        .out_ready_i(out_ready_i)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_case(input int cid, input bit poke);
        logic [NF*DW-1:0]    v;
        logic [NF*NF*DW-1:0] m;
        int                  ord [NF];
        logic [DW-1:0]       expd [TOT];
        int                  b, rp, k;
        logic [DW-1:0]       held;
        bit                  stalled;
        string               vtag;
        v = CASE_VALS[cid];
        for (int r = 0; r < NF; r++)
            for (int c = 0; c < NF; c++)
                m[(r*NF+c)*DW +: DW] = DW'(cid*4096 + r*16 + c + 1);
        // rank of i = count of values that beat it (larger, or equal with lower index)
        for (int i = 0; i < NF; i++) begin
            int p;
            p = 0;
            for (int j = 0; j < NF; j++)
                if ($signed(v[j*DW +: DW]) > $signed(v[i*DW +: DW]) ||
                    (v[j*DW +: DW] == v[i*DW +: DW] && j < i)) p++;
            ord[p] = i;
        end
        for (int i = 0; i < NF; i++) expd[i] = v[ord[i]*DW +: DW];
        for (int c = 0; c < NF; c++)
            for (int r = 0; r < NF; r++)
                expd[NF + c*NF + r] = m[(r*NF + ord[c])*DW +: DW];
        vtag = (cid == 2 || cid == 3) ? "R4" : "R3";

        @(negedge clk);
        vals_i = v; vecs_i = m; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        vals_i = ~v; vecs_i = ~m;           // R2: late input changes must not matter
        chk(busy_o === 1'b1, "R2 busy after start", 32'(busy_o), 1);
        k = 0;
        while (!out_valid_o && k < 1000) begin
            @(posedge clk); k++; @(negedge clk);
        end
        chk(k == NF*NF, "R11 first valid latency", 32'(k), NF*NF);
        b = 0; rp = 0; stalled = 0; held = '0;
        while (b < TOT && k < 5000) begin
            if (stalled)
                chk(out_valid_o && out_data_o == held, "R8 stall hold",
                    32'(out_data_o), 32'(held));
            if (out_valid_o) begin
                chk(out_data_o == expd[b], (b < NF) ? {vtag, "/R5 value"} : "R6 vector",
                    32'(out_data_o), 32'(expd[b]));
                chk(out_last_o == (b == TOT-1), "R7 last flag", 32'(out_last_o),
                    32'(b == TOT-1));
            end
            if (poke && b == 5) begin
                start_i = 1'b1;             // R9: ignored while busy
                vals_i = '1; vecs_i = '0;
            end else begin
                start_i = 1'b0;
            end
            out_ready_i = CASE_READY[cid][rp % 16];
            rp++;
            stalled = out_valid_o && !out_ready_i;
            held = out_data_o;
            if (out_valid_o && out_ready_i) b++;
            @(posedge clk); k++; @(negedge clk);
        end
        start_i = 1'b0;
        out_ready_i = 1'b0;
        chk(busy_o === 1'b0, "R10 busy falls", 32'(busy_o), 0);
        chk(out_valid_o === 1'b0, "R10 stream over", 32'(out_valid_o), 0);
        if (poke) chk(b == TOT, "R9 job not restarted", 32'(b), TOT);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R10 watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_o === 1'b0 && out_valid_o === 1'b0 && out_last_o === 1'b0,
            "R1 in reset", {29'd0, busy_o, out_valid_o, out_last_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o === 1'b0 && out_valid_o === 1'b0 && out_last_o === 1'b0,
            "R1 after reset", {29'd0, busy_o, out_valid_o, out_last_o}, 0);
        for (int c = 0; c < NCASE; c++) run_case(c, c == 1);
        // R10: back-to-back job, started in the first idle cycle
        run_case(2, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule